// File: doc/BRIEF.md
# Byte-Wide Stack Pointer Sequencer

This block owns a 16-bit stack pointer and carries out 16-bit stack transfers over a byte-wide synchronous memory port. A single start strobe with a command code launches one operation. The sequencer then steps through its byte accesses and raises a one-cycle completion pulse. The stack grows toward lower addresses, and the pointer always addresses the most recently written byte. Pushes decrement the pointer before each write. Pops increment it after each read.

Beyond push and pop, the block can swap a 16-bit operand with the two bytes at the top of the stack without moving the pointer. It can load the pointer from an operand (two command codes, one meant for a register pair and one for an immediate, with identical effect), and it can step the pointer up or down by one. The memory returns read data on the cycle after the read strobe, and the sequencer captures it there. The 16-bit value recovered by a pop or an exchange stays on `result` until the next such command. No status flags are produced.

States: `ST_IDLE` (accepts a start), `ST_PUSH_HI`, `ST_PUSH_LO`, `ST_POP_RD_LO`, `ST_POP_CAP_LO`, `ST_POP_RD_HI`, `ST_POP_CAP_HI`, `ST_XCH_RD_LO`, `ST_XCH_CAP_LO`, `ST_XCH_RD_HI`, `ST_XCH_CAP_HI`, `ST_XCH_WR_LO`, `ST_XCH_WR_HI` and `ST_FIN` (completion pulse).

Transitions:
- From `ST_IDLE` with start: push goes to `ST_PUSH_HI`, pop goes to `ST_POP_RD_LO`, exchange goes to `ST_XCH_RD_LO`, and every other code goes straight to `ST_FIN`.
- The push, pop and exchange chains each advance one state per cycle in the order listed above, and each ends in `ST_FIN`.
- `ST_FIN` always returns to `ST_IDLE`.

Top module: `stack_seq`

## Requirements
- R1: After reset, `sp_out` is 0x0000, `result` is 0x0000, and `done`, `mem_we` and `mem_re` are low.
- R2: Command 0 (push) writes operand bits 15:8 at SP-1, then operand bits 7:0 at SP-2. It leaves SP-2 in the pointer, makes exactly two writes, and raises `done` 3 cycles after the start edge. Write strobes come in an unbroken run that ends at `done`.
- R3: Command 1 (pop) reads the byte at SP into `result` bits 7:0 and the byte at SP+1 into bits 15:8. It leaves SP+2 in the pointer, makes exactly two reads, and raises `done` 5 cycles after the start edge.
- R4: Read data is taken in the cycle after `mem_re`. The cycle after a read strobe carries no strobe, and `mem_we` and `mem_re` are never high together.
- R5: Command 2 (exchange) reads SP and SP+1 into `result` (low byte at SP), then writes operand bits 7:0 at SP and bits 15:8 at SP+1. It makes two reads and two writes, leaves the pointer unchanged, and raises `done` 7 cycles after the start edge.
- R6: Commands 3 and 4 load the pointer from the operand, with `done` 1 cycle after the start edge.
- R7: Command 5 adds one and command 6 subtracts one from the pointer, wrapping modulo 2^16. The same wrap applies to push and pop addressing.
- R8: `done` is high for exactly one cycle per command. A start strobe while the sequencer is busy has no effect.
- R9: A push followed by a pop returns the pushed value and restores the original pointer, with stacked values coming back last in, first out.
- R10: Command 7 changes neither the pointer nor `result`, and raises `done` 1 cycle after the start edge.
- R11: Commands 3 to 7 make no memory access, and no strobe is high in the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch strobe, sampled only when idle |
| cmd | input | 3 | Command code (0 push, 1 pop, 2 exchange, 3/4 load, 5 increment, 6 decrement, 7 none) |
| operand | input | 16 | Value to push, exchange or load |
| mem_addr | output | 16 | Byte address of the current access |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data expected on `mem_rdata` the next cycle |
| mem_rdata | input | 8 | Read data from memory |
| result | output | 16 | Value recovered by the latest pop or exchange |
| sp_out | output | 16 | Current stack pointer |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a start strobe arriving mid-sequence. Normal use never does this, so the bench forces it: it holds `start` high with a different command code in the cycle right after a push has been accepted. It then checks that the push latency, the final pointer and the following idle cycle all match an undisturbed push. Pointer wrap through 0x0000 is reached by loading 0x0001 and pushing, which puts the two written bytes at 0x0000 and 0xFFFF.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    typedef enum logic [2:0] {
        CMD_PUSH   = 3'd0,
        CMD_POP    = 3'd1,
        CMD_XCHG   = 3'd2,
        CMD_LDPAIR = 3'd3,
        CMD_LDIMM  = 3'd4,
        CMD_INC    = 3'd5,
        CMD_DEC    = 3'd6,
        CMD_NONE   = 3'd7
    } stk_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_POP_RD_LO,
        ST_POP_CAP_LO,
        ST_POP_RD_HI,
        ST_POP_CAP_HI,
        ST_XCH_RD_LO,
        ST_XCH_CAP_LO,
        ST_XCH_RD_HI,
        ST_XCH_CAP_HI,
        ST_XCH_WR_LO,
        ST_XCH_WR_HI,
        ST_FIN
    } stk_state_e;

    typedef enum logic [1:0] {
        PTR_HOLD,
        PTR_INC,
        PTR_DEC,
        PTR_LOAD
    } ptr_op_e;

    localparam logic LANE_LO = 1'b0;
    localparam logic LANE_HI = 1'b1;

endpackage

// File: rtl/stack_ptr_reg.sv
module stack_ptr_reg
    import stack_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ptr_op_e           op,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] ptr_up
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= RST_VAL;
        end else begin
            unique case (op)
                PTR_INC:  ptr_q <= ptr_q + ONE;
                PTR_DEC:  ptr_q <= ptr_q - ONE;
                PTR_LOAD: ptr_q <= load_val;
                default:  ptr_q <= ptr_q;
            endcase
        end
    end

    assign ptr    = ptr_q;
    assign ptr_up = ptr_q + ONE;

endmodule

// File: rtl/pop_capture.sv
module pop_capture #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_en,
    input  logic [SEL_W-1:0]        cap_lane,
    input  logic [BYTE_W-1:0]       byte_in,
    output logic [BYTE_W*LANES-1:0] value
);

    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (cap_en && (cap_lane == SEL_W'(g))) begin
                lane_q <= byte_in;
            end
        end

        assign value[g*BYTE_W +: BYTE_W] = lane_q;
    end

endmodule

// File: rtl/stack_fsm.sv
module stack_fsm
    import stack_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] cmd,
    output logic       idle,
    output ptr_op_e    ptr_op,
    output logic       addr_up,
    output logic       wr_lane,
    output logic       cap_lane,
    output logic       cap_en,
    output logic       mem_we,
    output logic       mem_re,
    output logic       done
);

    stk_state_e state, nxt;
    stk_cmd_e   cmd_e;

    assign cmd_e = stk_cmd_e'(cmd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    unique case (cmd_e)
                        CMD_PUSH: nxt = ST_PUSH_HI;
                        CMD_POP:  nxt = ST_POP_RD_LO;
                        CMD_XCHG: nxt = ST_XCH_RD_LO;
                        default:  nxt = ST_FIN;
                    endcase
                end
            end
            ST_PUSH_HI:    nxt = ST_PUSH_LO;
            ST_PUSH_LO:    nxt = ST_FIN;
            ST_POP_RD_LO:  nxt = ST_POP_CAP_LO;
            ST_POP_CAP_LO: nxt = ST_POP_RD_HI;
            ST_POP_RD_HI:  nxt = ST_POP_CAP_HI;
            ST_POP_CAP_HI: nxt = ST_FIN;
            ST_XCH_RD_LO:  nxt = ST_XCH_CAP_LO;
            ST_XCH_CAP_LO: nxt = ST_XCH_RD_HI;
            ST_XCH_RD_HI:  nxt = ST_XCH_CAP_HI;
            ST_XCH_CAP_HI: nxt = ST_XCH_WR_LO;
            ST_XCH_WR_LO:  nxt = ST_XCH_WR_HI;
            ST_XCH_WR_HI:  nxt = ST_FIN;
            ST_FIN:        nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        idle     = 1'b0;
        ptr_op   = PTR_HOLD;
        addr_up  = 1'b0;
        wr_lane  = LANE_LO;
        cap_lane = LANE_LO;
        cap_en   = 1'b0;
        mem_we   = 1'b0;
        mem_re   = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle = 1'b1;
                if (start) begin
                    unique case (cmd_e)
                        CMD_PUSH, CMD_DEC:    ptr_op = PTR_DEC;
                        CMD_LDPAIR, CMD_LDIMM: ptr_op = PTR_LOAD;
                        CMD_INC:              ptr_op = PTR_INC;
                        default:              ptr_op = PTR_HOLD;
                    endcase
                end
            end
            ST_PUSH_HI: begin
                mem_we  = 1'b1;
                wr_lane = LANE_HI;
                ptr_op  = PTR_DEC;
            end
            ST_PUSH_LO: begin
                mem_we  = 1'b1;
                wr_lane = LANE_LO;
            end
            ST_POP_RD_LO, ST_POP_RD_HI, ST_XCH_RD_LO: begin
                mem_re = 1'b1;
            end
            ST_POP_CAP_LO: begin
                cap_en   = 1'b1;
                cap_lane = LANE_LO;
                ptr_op   = PTR_INC;
            end
            ST_POP_CAP_HI: begin
                cap_en   = 1'b1;
                cap_lane = LANE_HI;
                ptr_op   = PTR_INC;
            end
            ST_XCH_CAP_LO: begin
                cap_en   = 1'b1;
                cap_lane = LANE_LO;
            end
            ST_XCH_RD_HI: begin
                mem_re  = 1'b1;
                addr_up = 1'b1;
            end
            ST_XCH_CAP_HI: begin
                cap_en   = 1'b1;
                cap_lane = LANE_HI;
            end
            ST_XCH_WR_LO: begin
                mem_we  = 1'b1;
                wr_lane = LANE_LO;
            end
            ST_XCH_WR_HI: begin
                mem_we  = 1'b1;
                wr_lane = LANE_HI;
                addr_up = 1'b1;
            end
            ST_FIN: begin
                done = 1'b1;
            end
            default: begin
                idle = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter logic [ADDR_W-1:0] SP_RESET = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2:0]          cmd,
    input  logic [2*BYTE_W-1:0] operand,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    output logic                mem_we,
    output logic                mem_re,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic [2*BYTE_W-1:0] result,
    output logic [ADDR_W-1:0]   sp_out,
    output logic                done
);

    localparam int DATA_W = 2 * BYTE_W;

    logic              idle, addr_up, wr_lane, cap_lane, cap_en;
    ptr_op_e           ptr_op;
    logic [ADDR_W-1:0] ptr, ptr_up;
    logic [DATA_W-1:0] opnd_q;

    stack_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (cmd),
        .idle     (idle),
        .ptr_op   (ptr_op),
        .addr_up  (addr_up),
        .wr_lane  (wr_lane),
        .cap_lane (cap_lane),
        .cap_en   (cap_en),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .done     (done)
    );

    stack_ptr_reg #(
        .ADDR_W  (ADDR_W),
        .RST_VAL (SP_RESET)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (ptr_op),
        .load_val (ADDR_W'(operand)),
        .ptr      (ptr),
        .ptr_up   (ptr_up)
    );

    pop_capture #(
        .BYTE_W (BYTE_W),
        .LANES  (2)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_lane (cap_lane),
        .byte_in  (mem_rdata),
        .value    (result)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             opnd_q <= '0;
        else if (idle && start) opnd_q <= operand;
    end

    assign mem_addr  = addr_up ? ptr_up : ptr;
    assign mem_wdata = (wr_lane == LANE_HI) ? opnd_q[DATA_W-1:BYTE_W] : opnd_q[BYTE_W-1:0];
    assign sp_out    = ptr;

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_we,
    input logic mem_re,
    input logic done
);

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_read_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (!mem_re && !mem_we));

    assert_write_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_we || done));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_we && !mem_re));

endmodule

bind stack_seq stack_seq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_we (mem_we),
    .mem_re (mem_re),
    .done   (done)
);

// File: tb/sim_stack_seq.sv
`timescale 1ns/1ps
module sim_stack_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [15:0] operand = 16'h0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re;
    logic [7:0]  mem_rdata;
    logic [15:0] result, sp_out;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;
    int wr_total = 0;
    int rd_total = 0;

    logic [7:0] mem [256];

    always #5 clk = ~clk;

    stack_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .operand(operand),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .result(result), .sp_out(sp_out), .done(done)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_total <= wr_total + 1;
        end
        if (mem_re) begin
            mem_rdata <= mem[mem_addr[7:0]];
            rd_total <= rd_total + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [2:0] c, input logic [15:0] d, input string req,
                           input int exp_lat, input int exp_wr, input int exp_rd);
        int w0, r0, lat;
        w0 = wr_total;
        r0 = rd_total;
        lat = 0;
        @(negedge clk);
        cmd = c;
        operand = d;
        start = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (done) break;
        end
        chk(req, "latency", lat, exp_lat);
        chk(req, "write count", wr_total - w0, exp_wr);
        chk(req, "read count", rd_total - r0, exp_rd);
        @(negedge clk);
        chk("R8", "done single cycle", {31'b0, done}, 0);
    endtask

    task automatic t_reset;
        chk("R1", "sp after reset", sp_out, 16'h0000);
        chk("R1", "result after reset", result, 16'h0000);
        chk("R1", "done after reset", {31'b0, done}, 0);
        chk("R1", "strobes after reset", {30'b0, mem_we, mem_re}, 0);
    endtask

    task automatic t_load;
        run_cmd(3'd4, 16'h0040, "R6", 1, 0, 0);
        chk("R6", "sp after immediate load", sp_out, 16'h0040);
        run_cmd(3'd3, 16'h0080, "R11", 1, 0, 0);
        chk("R6", "sp after pair load", sp_out, 16'h0080);
    endtask

    task automatic t_push_pop;
        run_cmd(3'd0, 16'hA1B2, "R2", 3, 2, 0);
        chk("R2", "sp after push", sp_out, 16'h007E);
        chk("R2", "high byte at sp-1", mem[8'h7F], 8'hA1);
        chk("R2", "low byte at sp-2", mem[8'h7E], 8'hB2);
        run_cmd(3'd0, 16'h3344, "R2", 3, 2, 0);
        chk("R2", "sp after second push", sp_out, 16'h007C);
        run_cmd(3'd1, 16'h0000, "R3", 5, 0, 2);
        chk("R9", "first pop gets last push", result, 16'h3344);
        chk("R3", "sp after pop", sp_out, 16'h007E);
        run_cmd(3'd1, 16'h0000, "R3", 5, 0, 2);
        chk("R9", "second pop gets first push", result, 16'hA1B2);
        chk("R9", "pointer restored", sp_out, 16'h0080);
    endtask

    task automatic t_xchg;
        run_cmd(3'd0, 16'h5566, "R2", 3, 2, 0);
        run_cmd(3'd2, 16'h7788, "R5", 7, 2, 2);
        chk("R5", "old top returned", result, 16'h5566);
        chk("R5", "sp unchanged", sp_out, 16'h007E);
        chk("R5", "low byte written at sp", mem[8'h7E], 8'h88);
        chk("R5", "high byte written at sp+1", mem[8'h7F], 8'h77);
        run_cmd(3'd1, 16'h0000, "R5", 5, 0, 2);
        chk("R5", "pop after exchange", result, 16'h7788);
        chk("R9", "sp after pop", sp_out, 16'h0080);
    endtask

    task automatic t_wrap;
        run_cmd(3'd4, 16'hFFFF, "R6", 1, 0, 0);
        run_cmd(3'd5, 16'h1234, "R7", 1, 0, 0);
        chk("R7", "increment wraps to 0", sp_out, 16'h0000);
        run_cmd(3'd6, 16'h1234, "R7", 1, 0, 0);
        chk("R7", "decrement wraps to FFFF", sp_out, 16'hFFFF);
        run_cmd(3'd4, 16'h0001, "R6", 1, 0, 0);
        run_cmd(3'd0, 16'hC3D4, "R7", 3, 2, 0);
        chk("R7", "sp after wrapping push", sp_out, 16'hFFFF);
        chk("R7", "high byte at 0000", mem[8'h00], 8'hC3);
        chk("R7", "low byte at FFFF", mem[8'hFF], 8'hD4);
        run_cmd(3'd1, 16'h0000, "R7", 5, 0, 2);
        chk("R7", "pop across wrap", result, 16'hC3D4);
        chk("R7", "sp after wrapping pop", sp_out, 16'h0001);
    endtask

    task automatic t_none;
        run_cmd(3'd7, 16'hBEEF, "R10", 1, 0, 0);
        chk("R10", "sp unchanged", sp_out, 16'h0001);
        chk("R10", "result unchanged", result, 16'hC3D4);
    endtask

    task automatic t_busy;
        int lat;
        run_cmd(3'd4, 16'h0080, "R6", 1, 0, 0);
        lat = 0;
        @(negedge clk);
        cmd = 3'd0;
        operand = 16'h1234;
        start = 1'b1;
        @(negedge clk);
        lat++;
        cmd = 3'd5;
        start = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (done) break;
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        chk("R8", "push latency with busy start", lat, 3);
        @(negedge clk);
        chk("R8", "done after busy push", {31'b0, done}, 0);
        @(negedge clk);
        chk("R8", "busy start ignored, sp", sp_out, 16'h007E);
        chk("R8", "pushed high byte intact", mem[8'h7F], 8'h12);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_load();
        t_push_pop();
        t_xchg();
        t_wrap();
        t_none();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule